// File: doc/BRIEF.md
# Falling-Edge Interrupt Event Latch

This block watches two 8-bit groups of input pins and records falling edges as sticky event bits. Each group has its own interrupt enable byte. The event bits of both groups drive a single active-low interrupt line. A host writes the enable bytes through strobes, reads the event bytes, and acknowledges all pending events with one clear strobe. A synchronous software reset returns every register to zero.

The second group can also drive outputs. Its pins are arranged in direction groups of four pins. A direction input marks each group as input (0) or output (1). Edges on pins whose group is in output mode never raise an event.

The pins arrive asynchronously. Each pin passes through two synchronizer flops and then one history flop before its edge is detected.

Top module: `edge_event_latch`

## Requirements
- R1: An event bit sets when its pin falls while the matching enable bit is 1. The bit first reads 1 after the third rising clock edge that follows the pin change.
- R2: A falling edge on a pin whose enable bit is 0 is discarded. Setting the enable bit later does not recover it. A rising edge never sets an event bit.
- R3: `irq_n` is 0 while any event bit of either group is 1. It is 1 when every event bit is 0.
- R4: An event bit stays set after its pin returns high. It is cleared only by `clr_evt`, by `soft_rst` or by `rst_n`.
- R5: A single `clr_evt` cycle clears both event bytes at the same clock edge.
- R6: A falling edge detected in the same cycle as `clr_evt` still sets its bit, so the new event wins over the clear. All other bits are cleared.
- R7: A pin of group B can raise an event only while `dir_b[i/4]` is 0 (input). An edge on a pin of a group in output mode (1) is discarded.
- R8: `rst_n` low, or `soft_rst` high for one cycle, sets both enable bytes and both event bytes to 0. `irq_n` then reads 1.
- R9: The first synchronized sample after reset is not treated as an edge. A pin held low through reset raises no event, even when its enable bit is 1.
- R10: `wr_en_a` loads `wdata` into the group A enables only, and `wr_en_b` loads it into the group B enables only. A new enable takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_a | input | W | Group A pins, asynchronous |
| pin_b | input | W | Group B pins, asynchronous |
| dir_b | input | W/GRP | Group B direction per group of GRP pins, 1 = output |
| wr_en_a | input | 1 | Write strobe for the group A enable byte |
| wr_en_b | input | 1 | Write strobe for the group B enable byte |
| wdata | input | W | Enable write data |
| clr_evt | input | 1 | Clears both event bytes |
| soft_rst | input | 1 | Synchronous clear of all enables and events |
| evt_a | output | W | Group A event bits |
| evt_b | output | W | Group B event bits |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The tests apply several kinds of pin activity:
- A single falling edge on an enabled pin. This checks the exact latency and the interrupt level.
- Falling edges on disabled pins, followed by a later enable. This separates edge detection from level sampling.
- Rising edges, which show that only falls count.
- A pin held low through reset. This separates a true edge from the reset value of the synchronizer.

Further tests apply patterns that cover two or more pins at once. Edges on group B pins split across input and output direction groups check the direction mask. A fall timed to land in the same cycle as the clear strobe shows which of the two takes priority.

// File: rtl/edge_event_latch.sv
`timescale 1ns/1ps
module edge_event_latch #(
  parameter int W   = 8,
  parameter int GRP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     pin_a,
  input  logic [W-1:0]     pin_b,
  input  logic [W/GRP-1:0] dir_b,
  input  logic             wr_en_a,
  input  logic             wr_en_b,
  input  logic [W-1:0]     wdata,
  input  logic             clr_evt,
  input  logic             soft_rst,
  output logic [W-1:0]     evt_a,
  output logic [W-1:0]     evt_b,
  output logic             irq_n
);
  localparam int NG = W / GRP;

  logic [W-1:0] a_s1, a_s2, a_prev;
  logic [W-1:0] b_s1, b_s2, b_prev;
  logic [2:0]   fill;
  logic         live;
  logic [W-1:0] en_a, en_b;
  logic [W-1:0] in_mask_b;
  logic [W-1:0] fall_a, fall_b;
  logic [W-1:0] hit_a, hit_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_s1   <= '1;
      a_s2   <= '1;
      a_prev <= '1;
      b_s1   <= '1;
      b_s2   <= '1;
      b_prev <= '1;
      fill   <= '0;
    end else begin
      a_s1   <= pin_a;
      a_s2   <= a_s1;
      a_prev <= a_s2;
      b_s1   <= pin_b;
      b_s2   <= b_s1;
      b_prev <= b_s2;
      fill   <= {fill[1:0], 1'b1};
    end
  end

  assign live = fill[2];

  for (genvar g = 0; g < NG; g++) begin : g_dir
    assign in_mask_b[g*GRP +: GRP] = {GRP{~dir_b[g]}};
  end

  assign fall_a = live ? (a_prev & ~a_s2) : '0;
  assign fall_b = live ? (b_prev & ~b_s2) : '0;
  assign hit_a  = fall_a & en_a;
  assign hit_b  = fall_b & en_b & in_mask_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a <= '0;
      en_b <= '0;
    end else if (soft_rst) begin
      en_a <= '0;
      en_b <= '0;
    end else begin
      if (wr_en_a) en_a <= wdata;
      if (wr_en_b) en_b <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_a <= '0;
      evt_b <= '0;
    end else if (soft_rst) begin
      evt_a <= '0;
      evt_b <= '0;
    end else begin
      evt_a <= (clr_evt ? '0 : evt_a) | hit_a;
      evt_b <= (clr_evt ? '0 : evt_b) | hit_b;
    end
  end

  assign irq_n = ~(|evt_a | |evt_b);

  // New event bits need an enable in the cycle before
  p_new_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((evt_a & ~$past(evt_a) & ~$past(en_a)) == '0) &&
              ((evt_b & ~$past(evt_b) & ~$past(en_b)) == '0)));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && !soft_rst) |=> (((evt_a & $past(evt_a)) == $past(evt_a)) &&
                                 ((evt_b & $past(evt_b)) == $past(evt_b))));

  p_clear_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (((evt_a & ~$past(fall_a)) == '0) && ((evt_b & ~$past(fall_b)) == '0)));

  p_out_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_b & ~$past(evt_b) & ~$past(in_mask_b)) == '0));

  p_soft_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (evt_a == '0 && evt_b == '0 && irq_n));

  p_irq_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(clr_evt || soft_rst));

  p_first_sample_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (evt_a == '0 && evt_b == '0));
endmodule

// File: tb/sim_edge_event_latch.sv
`timescale 1ns/1ps
module sim_edge_event_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_a = 8'hFF, pin_b = 8'hFF;
  logic [1:0] dir_b = 2'b00;
  logic       wr_en_a = 1'b0, wr_en_b = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       clr_evt = 1'b0, soft_rst = 1'b0;
  logic [7:0] evt_a, evt_b;
  logic       irq_n;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  edge_event_latch #(.W(8), .GRP(4)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .dir_b(dir_b),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wdata(wdata),
    .clr_evt(clr_evt), .soft_rst(soft_rst),
    .evt_a(evt_a), .evt_b(evt_b), .irq_n(irq_n));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_en(input logic sel_b, input logic [7:0] d);
    wdata = d;
    if (sel_b) wr_en_b = 1'b1; else wr_en_a = 1'b1;
    step(1);
    wr_en_a = 1'b0;
    wr_en_b = 1'b0;
  endtask

  task automatic pulse_clear();
    clr_evt = 1'b1;
    step(1);
    clr_evt = 1'b0;
  endtask

  task automatic t_reset();
    pin_a = 8'hFE;
    step(3);
    rst_n = 1'b1;
    chk("R8 evt_a at reset", evt_a, 8'h00);
    chk("R8 irq_n at reset", {7'b0, irq_n}, 8'h01);
    write_en(1'b0, 8'hFF);
    step(4);
    chk("R9 pin low through reset", evt_a, 8'h00);
    pin_a = 8'hFF;
    step(4);
  endtask

  task automatic t_basic();
    write_en(1'b0, 8'h0F);
    pin_a[2] = 1'b0;
    step(2);
    chk("R1 not yet after two edges", evt_a, 8'h00);
    step(1);
    chk("R1 set on third edge", evt_a, 8'h04);
    chk("R3 irq low with event", {7'b0, irq_n}, 8'h00);
    pin_a[2] = 1'b1;
    step(4);
    chk("R4 sticky after pin high", evt_a, 8'h04);
  endtask

  task automatic t_disabled();
    pin_a[5] = 1'b0;
    step(4);
    chk("R2 disabled pin ignored", evt_a, 8'h04);
    write_en(1'b0, 8'hFF);
    step(4);
    chk("R2 not remembered after enable", evt_a, 8'h04);
    pin_a[5] = 1'b1;
    step(4);
    chk("R2 rising edge ignored", evt_a, 8'h04);
  endtask

  task automatic t_clear();
    write_en(1'b1, 8'h01);
    pin_b = 8'hFC;
    step(4);
    chk("R10 group B enable byte", evt_b, 8'h01);
    chk("R10 group A unchanged", evt_a, 8'h04);
    pulse_clear();
    chk("R5 clear group A", evt_a, 8'h00);
    chk("R5 clear group B", evt_b, 8'h00);
    chk("R3 irq high after clear", {7'b0, irq_n}, 8'h01);
    pin_b = 8'hFF;
    step(4);
  endtask

  task automatic t_dir();
    dir_b = 2'b10;
    write_en(1'b1, 8'hFF);
    pin_b = 8'b1011_1101;
    step(4);
    chk("R7 output group masked", evt_b, 8'h02);
    pin_b = 8'hFF;
    dir_b = 2'b00;
    step(4);
    chk("R7 no event from direction change", evt_b, 8'h02);
    pulse_clear();
    step(1);
  endtask

  task automatic t_collide();
    pin_a[0] = 1'b0;
    step(4);
    chk("R1 second pin event", evt_a, 8'h01);
    pin_a[3] = 1'b0;
    step(2);
    clr_evt = 1'b1;
    step(1);
    clr_evt = 1'b0;
    chk("R6 edge wins over clear", evt_a, 8'h08);
    pin_a = 8'hFF;
    step(4);
    pulse_clear();
  endtask

  task automatic t_soft();
    pin_a[1] = 1'b0;
    step(4);
    chk("R1 before soft reset", evt_a, 8'h02);
    soft_rst = 1'b1;
    step(1);
    soft_rst = 1'b0;
    chk("R8 soft reset events", evt_a, 8'h00);
    chk("R8 soft reset irq", {7'b0, irq_n}, 8'h01);
    pin_a[1] = 1'b1;
    step(3);
    pin_a[4] = 1'b0;
    pin_b[3] = 1'b0;
    step(4);
    chk("R8 enables cleared A", evt_a, 8'h00);
    chk("R8 enables cleared B", evt_b, 8'h00);
    pin_a = 8'hFF;
    pin_b = 8'hFF;
    step(2);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_disabled();
    t_clear();
    t_dir();
    t_collide();
    t_soft();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule